// File: doc/BRIEF.md
# Staircase Band Gate Generator

This block drives the slow high-voltage switches of a single-phase 13-level switched-capacitor inverter. A phase accumulator advances by a programmable step on every clock. Its top bits feed a parabolic half-wave sine, and the result is scaled by three times a modulation index. This gives a signed reference in units of the DC input, with a range of plus or minus three.

Each cycle the reference is placed in one of six bands, and each band selects a fixed pattern for four of the gates. The fifth gate and its complement follow the sign of the reference, with a dead time inserted between them. The reference and the band index are also exported, for use by the fast pulse-width modulator of the low-voltage stage.

The high-voltage gates therefore change state only when the reference crosses a band boundary. They never change at the carrier rate.

Top module: `stair_gate_gen`

## Requirements
- R1: While `rst_ni` is low, `sw_o`, `top_o` and `top_n_o` are 0, `ref_o` is 0 and `band_o` is 2. After release, `top_o` and `top_n_o` both stay low for DEAD_CYC+1 clock edges.
- R2: The phase starts at 0 after reset and adds `step_i` on every clock edge, modulo 2^PHASE_W. After an edge, `ref_o` reflects the phase held before that edge, computed as follows.
  - u is the SIN_W bits just below the phase sign bit.
  - mag = floor(u·(2^SIN_W−u) / 2^(SIN_W−2)).
  - ref = floor(3·mod_i·mag / 2^MOD_FRAC), negated when the phase sign bit is 1.
  - 1.0 equals 2^SIN_W.
- R3: `band_o` is registered in the same cycle as `ref_o` and is encoded as follows: 0 when ref > 2; 1 when 1 < ref ≤ 2; 2 when 0 ≤ ref ≤ 1; 3 when −1 ≤ ref < 0; 4 when −2 ≤ ref < −1; 5 when ref < −2. A reference that lies exactly on a threshold takes the band of lower magnitude.
- R4: `sw_o` = {S2,S3,S4,S5} follows `band_o` in the same cycle: band 0 gives 0100, band 1 gives 1001, band 2 gives 0010, band 3 gives 0100, band 4 gives 1001, band 5 gives 0010.
- R5: `top_o` and `top_n_o` are never high together. When either is high, `top_o` is 1 exactly when the band one cycle earlier was 0, 1 or 2, and `top_n_o` is its complement.
- R6: The cycle after the band moves between the upper half (0..2) and the lower half (3..5), both `top_o` and `top_n_o` drop low. They stay low for exactly DEAD_CYC cycles before the new one rises.
- R7: At a modulation index of 1.0, one output period contains the following edge counts: 8 on S2, 6 on S3, 6 on S4, 8 on S5 and 2 on `top_o`. These counts do not depend on the step size.
- R8: At an index of 1.0, bands 0 and 5 are both reached. At an index below 2/3, bands 0 and 5 never occur.
- R9: |ref_o| never exceeds floor(3·mod·2^SIN_W / 2^MOD_FRAC), where mod is the index applied one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | PHASE_W | Phase increment added on each clock |
| mod_i | input | MOD_FRAC+1 | Modulation index, unsigned, 1.0 = 2^MOD_FRAC |
| ref_o | output | SIN_W+4 | Signed reference, 1.0 = 2^SIN_W |
| band_o | output | 3 | Band index 0..5 |
| sw_o | output | 4 | Gates {S2,S3,S4,S5} |
| top_o | output | 1 | Gate S6, high for the upper half of the reference |
| top_n_o | output | 1 | Complement gate of S6, with dead time |

## Verification
The timing of each output is as follows:
- `ref_o`, `band_o` and `sw_o` all appear one edge after the phase they describe, so all three are checked against the same sample.
- The S6 pair reacts one edge after a band change. It then spends DEAD_CYC cycles with both gates low.

The bench keeps its own phase and reference model, updated on the rising edge in step with the design. It samples every output on the falling edge. Its checks of S6 against the band use the band sampled one cycle earlier. Threshold ties are reached by choosing an index and a step that land the phase on a computed exact-tie point, and the result is read two edges after reset release.

// File: rtl/stair_pkg.sv
`timescale 1ns/1ps
package stair_pkg;
  typedef enum logic [2:0] {
    BAND_A = 3'd0,
    BAND_B = 3'd1,
    BAND_C = 3'd2,
    BAND_D = 3'd3,
    BAND_E = 3'd4,
    BAND_F = 3'd5
  } band_e;

  // {S2,S3,S4,S5} per band
  function automatic logic [3:0] band_gates(band_e b);
    case (b)
      BAND_A, BAND_D: return 4'b0100;
      BAND_B, BAND_E: return 4'b1001;
      default:        return 4'b0010;
    endcase
  endfunction

  function automatic logic band_upper(band_e b);
    return (b == BAND_A) || (b == BAND_B) || (b == BAND_C);
  endfunction
endpackage

// File: rtl/stair_phase_acc.sv
`timescale 1ns/1ps
module stair_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] step_i,
  output logic [OUT_W-1:0]   phase_o
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + step_i;
  end

  assign phase_o = acc_q[PHASE_W-1 -: OUT_W];
endmodule

// File: rtl/stair_ref_gen.sv
`timescale 1ns/1ps
module stair_ref_gen #(
  parameter int SIN_W    = 14,
  parameter int MOD_FRAC = 8,
  localparam int MOD_W   = MOD_FRAC + 1,
  localparam int REF_W   = SIN_W + 4
) (
  input  logic [SIN_W:0]           phase_i,
  input  logic [MOD_W-1:0]         mod_i,
  output logic signed [REF_W-1:0]  ref_d_o
);
  localparam int MAG_W  = SIN_W + 1;
  localparam int PROD_W = 2 * SIN_W + 2;
  localparam int SCL_W  = MAG_W + MOD_W + 2;

  logic [MAG_W-1:0]  u_ext, u_comp, mag;
  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [REF_W-1:0]  mag_s;

  // parabolic half-wave: 4u(1-u), peak 1.0 at u = 1/2
  assign u_ext  = {1'b0, phase_i[SIN_W-1:0]};
  assign u_comp = {1'b1, {SIN_W{1'b0}}} - u_ext;
  assign prod   = PROD_W'(u_ext) * PROD_W'(u_comp);
  assign mag    = MAG_W'(prod >> (SIN_W - 2));
  assign scaled = SCL_W'(mag) * SCL_W'(mod_i) * SCL_W'(3);
  assign mag_s  = REF_W'(scaled >> MOD_FRAC);

  assign ref_d_o = phase_i[SIN_W] ? -$signed(mag_s) : $signed(mag_s);
endmodule

// File: rtl/stair_band_map.sv
`timescale 1ns/1ps
module stair_band_map
  import stair_pkg::*;
#(
  parameter int SIN_W  = 14,
  localparam int REF_W = SIN_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_d_i,
  output logic signed [REF_W-1:0] ref_o,
  output band_e                   band_o,
  output logic [3:0]              sw_o
);
  localparam logic signed [REF_W-1:0] LVL_1  = REF_W'(1 << SIN_W);
  localparam logic signed [REF_W-1:0] LVL_2  = REF_W'(2 << SIN_W);
  localparam logic signed [REF_W-1:0] LVL_N1 = -LVL_1;
  localparam logic signed [REF_W-1:0] LVL_N2 = -LVL_2;
  localparam logic signed [REF_W-1:0] LVL_0  = '0;

  band_e band_d;

  // ties resolve toward the lower-magnitude band
  always_comb begin
    if      (ref_d_i >  LVL_2)  band_d = BAND_A;
    else if (ref_d_i >  LVL_1)  band_d = BAND_B;
    else if (ref_d_i >= LVL_0)  band_d = BAND_C;
    else if (ref_d_i >= LVL_N1) band_d = BAND_D;
    else if (ref_d_i >= LVL_N2) band_d = BAND_E;
    else                        band_d = BAND_F;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o  <= '0;
      band_o <= BAND_C;
      sw_o   <= '0;
    end else begin
      ref_o  <= ref_d_i;
      band_o <= band_d;
      sw_o   <= band_gates(band_d);
    end
  end
endmodule

// File: rtl/stair_dead_pair.sv
`timescale 1ns/1ps
module stair_dead_pair #(
  parameter int DEAD_CYC = 34,
  localparam int CNT_W   = $clog2(DEAD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  output logic top_o,
  output logic top_n_o
);
  logic             held_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  // any change of the wanted side restarts the blanking window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      cnt_q  <= CNT_W'(DEAD_CYC);
    end else if (want_i != held_q) begin
      held_q <= want_i;
      cnt_q  <= CNT_W'(DEAD_CYC);
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign idle    = (cnt_q == '0);
  assign top_o   = idle &  held_q;
  assign top_n_o = idle & ~held_q;
endmodule

// File: rtl/stair_gate_gen.sv
`timescale 1ns/1ps
module stair_gate_gen
  import stair_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int SIN_W    = 14,
  parameter int MOD_FRAC = 8,
  parameter int DEAD_CYC = 34,
  localparam int MOD_W   = MOD_FRAC + 1,
  localparam int REF_W   = SIN_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      step_i,
  input  logic [MOD_W-1:0]        mod_i,
  output logic signed [REF_W-1:0] ref_o,
  output logic [2:0]              band_o,
  output logic [3:0]              sw_o,
  output logic                    top_o,
  output logic                    top_n_o
);
  logic [SIN_W:0]           phase;
  logic signed [REF_W-1:0]  ref_d;
  band_e                    band_q;

  stair_phase_acc #(.PHASE_W(PHASE_W), .OUT_W(SIN_W + 1)) u_acc (
    .clk_i, .rst_ni, .step_i, .phase_o(phase)
  );

  stair_ref_gen #(.SIN_W(SIN_W), .MOD_FRAC(MOD_FRAC)) u_ref (
    .phase_i(phase), .mod_i, .ref_d_o(ref_d)
  );

  stair_band_map #(.SIN_W(SIN_W)) u_band (
    .clk_i, .rst_ni, .ref_d_i(ref_d), .ref_o, .band_o(band_q), .sw_o
  );

  stair_dead_pair #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i, .rst_ni, .want_i(band_upper(band_q)), .top_o, .top_n_o
  );

  assign band_o = band_q;
endmodule

// File: rtl/stair_gate_chk.sv
`timescale 1ns/1ps
module stair_gate_chk #(
  parameter int SIN_W    = 14,
  parameter int MOD_FRAC = 8,
  parameter int DEAD_CYC = 34,
  localparam int MOD_W   = MOD_FRAC + 1,
  localparam int REF_W   = SIN_W + 4,
  localparam int LIM_W   = SIN_W + MOD_W + 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [MOD_W-1:0]        mod_i,
  input logic signed [REF_W-1:0] ref_o,
  input logic [2:0]              band_o,
  input logic [3:0]              sw_o,
  input logic                    top_o,
  input logic                    top_n_o
);
  localparam logic signed [REF_W-1:0] T1 = REF_W'(1 << SIN_W);
  localparam logic signed [REF_W-1:0] T2 = REF_W'(2 << SIN_W);

  logic [1:0]       live_q;
  logic [MOD_W-1:0] mod_q;
  logic [15:0]      gap_q;
  logic [2:0]       exp_band;
  logic [3:0]       exp_sw;
  logic [REF_W-1:0] ref_abs;
  logic [LIM_W-1:0] lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      mod_q  <= '0;
      gap_q  <= '0;
    end else begin
      live_q <= {live_q[0], 1'b1};
      mod_q  <= mod_i;
      if (!top_o && !top_n_o) begin
        if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
      end else begin
        gap_q <= '0;
      end
    end
  end

  always_comb begin
    if      (ref_o > T2)   exp_band = 3'd0;
    else if (ref_o > T1)   exp_band = 3'd1;
    else if (ref_o >= 0)   exp_band = 3'd2;
    else if (ref_o >= -T1) exp_band = 3'd3;
    else if (ref_o >= -T2) exp_band = 3'd4;
    else                   exp_band = 3'd5;
  end

  always_comb begin
    case (band_o)
      3'd0:    exp_sw = 4'b0100;
      3'd1:    exp_sw = 4'b1001;
      3'd2:    exp_sw = 4'b0010;
      3'd3:    exp_sw = 4'b0100;
      3'd4:    exp_sw = 4'b1001;
      3'd5:    exp_sw = 4'b0010;
      default: exp_sw = 4'b1111;
    endcase
  end

  assign ref_abs = ref_o[REF_W-1] ? REF_W'(-ref_o) : REF_W'(ref_o);
  assign lim     = ((LIM_W'(mod_q) * LIM_W'(3)) << SIN_W) >> MOD_FRAC;

  p_band_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_o == exp_band);

  p_pattern_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q[0] |-> sw_o == exp_sw);

  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_o && top_n_o));

  p_dead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((top_o || top_n_o) && gap_q != 16'd0) |-> gap_q >= 16'(DEAD_CYC));

  p_slow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q[1] && $stable(band_o)) |-> $stable(sw_o));

  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q[0] |-> LIM_W'(ref_abs) <= lim);
endmodule

bind stair_gate_gen stair_gate_chk #(
  .SIN_W(SIN_W), .MOD_FRAC(MOD_FRAC), .DEAD_CYC(DEAD_CYC)
) u_chk (.*);

// File: tb/sim_stair_gate_gen.sv
`timescale 1ns/1ps
module sim_stair_gate_gen;
  localparam int PW = 32;
  localparam int SW = 14;
  localparam int MF = 8;
  localparam int DC = 34;
  localparam int RW = SW + 4;
  localparam longint ONE = 64'd1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [PW-1:0] step = '0;
  logic [MF:0] mod = '0;
  logic signed [RW-1:0] ref_w;
  logic [2:0] band;
  logic [3:0] sw;
  logic top, topn;

  always #2.5 clk = ~clk;

  stair_gate_gen #(.PHASE_W(PW), .SIN_W(SW), .MOD_FRAC(MF), .DEAD_CYC(DC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .mod_i(mod),
    .ref_o(ref_w), .band_o(band), .sw_o(sw), .top_o(top), .top_n_o(topn)
  );

  int checks = 0, errors = 0;
  bit seen_a, seen_f;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_of(logic [PW-1:0] ph, longint m);
    longint u, mag, r;
    u   = longint'(ph[PW-2 -: SW]);
    mag = (u * (ONE - u)) >> (SW - 2);
    r   = (3 * m * mag) >> MF;
    return ph[PW-1] ? -r : r;
  endfunction

  function automatic int band_of(longint r);
    if (r > 2 * ONE)   return 0;
    if (r > ONE)       return 1;
    if (r >= 0)        return 2;
    if (r >= -ONE)     return 3;
    if (r >= -2 * ONE) return 4;
    return 5;
  endfunction

  function automatic int pat_of(int b);
    case (b)
      0, 3:    return 4'b0100;
      1, 4:    return 4'b1001;
      default: return 4'b0010;
    endcase
  endfunction

  // reference model of phase and reference
  logic [PW-1:0] mphase;
  longint mref;
  int nedge;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mphase <= '0; mref <= 0; nedge <= 0;
    end else begin
      mphase <= mphase + step;
      mref   <= ref_of(mphase, longint'(mod));
      nedge  <= nedge + 1;
    end
  end

  int lowcnt, band_prev;
  bit seen_on;
  always @(negedge clk) begin
    if (!rst_n) begin
      lowcnt = 0; seen_on = 0; band_prev = 2;
    end else begin
      longint a, lim;
      chk(longint'(ref_w) == mref, "R2 ref", ref_w, mref);
      chk(int'(band) == band_of(ref_w), "R3 band", band, band_of(ref_w));
      if (nedge >= 1) chk(int'(sw) == pat_of(band), "R4 pattern", sw, pat_of(band));
      a   = (ref_w < 0) ? -longint'(ref_w) : longint'(ref_w);
      lim = (3 * longint'(mod) * ONE) >> MF;
      chk(a <= lim, "R9 range", a, lim);
      chk(!(top && topn), "R5 exclusive", {top, topn}, 0);
      if (top || topn) begin
        chk(top == (band_prev <= 2), "R5 side", top, band_prev <= 2);
        if (seen_on && lowcnt > 0) chk(lowcnt == DC, "R6 dead", lowcnt, DC);
        seen_on = 1; lowcnt = 0;
      end else begin
        lowcnt++;
      end
      if (band == 3'd0) seen_a = 1;
      if (band == 3'd5) seen_f = 1;
      band_prev = band;
    end
  end

  task automatic do_reset(int m, logic [PW-1:0] st);
    rst_n = 1'b0; mod = m[MF:0]; step = st;
    repeat (3) @(negedge clk);
    chk(sw == 0 && !top && !topn, "R1 gates", {sw, top, topn}, 0);
    chk(ref_w == 0 && band == 3'd2, "R1 ref/band", {ref_w, band}, 2);
    seen_a = 0; seen_f = 0;
    rst_n = 1'b1;
  endtask

  task automatic count_period();
    int e[5];
    logic [3:0] psw;
    logic ptop;
    foreach (e[k]) e[k] = 0;
    psw = sw; ptop = top;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      for (int b = 0; b < 4; b++) if (sw[b] != psw[b]) e[3-b]++;
      if (top != ptop) e[4]++;
      psw = sw; ptop = top;
    end
    chk(e[0] == 8, "R7 S2 edges", e[0], 8);
    chk(e[1] == 6, "R7 S3 edges", e[1], 6);
    chk(e[2] == 6, "R7 S4 edges", e[2], 6);
    chk(e[3] == 8, "R7 S5 edges", e[3], 8);
    chk(e[4] == 2, "R7 S6 edges", e[4], 2);
  endtask

  task automatic tie_test(int mult, bit neg);
    longint tgt;
    int fm, fu, expb;
    tgt = mult * ONE; fm = -1; fu = 0;
    for (int m = 256; m > 128 && fm < 0; m--)
      for (int u = 1; u < 8192 && fm < 0; u++)
        if (((3 * longint'(m) * ((longint'(u) * (ONE - u)) >> (SW - 2))) >> MF) == tgt) begin
          fm = m; fu = u;
        end
    if (fm < 0) begin
      chk(0, "R3 tie search", 0, tgt);
    end else begin
      do_reset(fm, {neg, PW'(fu) << (PW - 1 - SW)} [PW-1:0] | (PW'(neg) << (PW - 1)));
      do @(negedge clk); while (nedge < 2);
      expb = (mult == 1) ? (neg ? 3 : 2) : (neg ? 4 : 1);
      chk(longint'(ref_w) == (neg ? -tgt : tgt), "R3 tie value", ref_w, neg ? -tgt : tgt);
      chk(int'(band) == expb, "R3 tie band", band, expb);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    #1;
    // R1: zero index, blanking after release then S6 on for band C
    do_reset(0, '0);
    do @(negedge clk); while (nedge < DC);
    chk(!top && !topn, "R1 post-reset blank", {top, topn}, 0);
    repeat (2) @(negedge clk);
    chk(top && !topn, "R1 S6 after blank", {top, topn}, 2);

    // full index, 2048-cycle period
    do_reset(256, PW'(1) << 21);
    repeat (4096) @(negedge clk);
    count_period();
    chk(seen_a && seen_f, "R8 full reaches A/F", {seen_a, seen_f}, 3);

    // reduced index 0.5 and 0.6
    do_reset(128, PW'(1) << 21);
    repeat (4096) @(negedge clk);
    chk(!seen_a && !seen_f, "R8 reduced no A/F", {seen_a, seen_f}, 0);
    do_reset(154, PW'(3) << 20);
    repeat (3000) @(negedge clk);
    chk(!seen_a && !seen_f, "R8 reduced 0.6 no A/F", {seen_a, seen_f}, 0);

    // zero tie: phase with sign set and u = 0
    do_reset(256, PW'(1) << (PW - 1));
    do @(negedge clk); while (nedge < 2);
    chk(ref_w == 0 && band == 3'd2, "R3 tie zero", band, 2);

    tie_test(1, 1'b0);
    tie_test(2, 1'b0);
    tie_test(1, 1'b1);
    tie_test(2, 1'b1);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule